// File: doc/BRIEF.md
# Circular-Buffer Pointer Wrap Unit

This block sits beside a data-address generator and corrects pointer updates so that a pointer bound to a circular buffer never leaves it. Two address spaces (X and Y) each own one buffer. A buffer is described by a first-word address, a last-word address, an enable and the number of the working register that acts as its pointer. Software therefore never tests buffer limits inside tight loops.

On each update the caller presents the old pointer, a signed byte step, the register number and the space. If the register is the bound pointer of an enabled buffer in that space, the sum is folded back into the buffer. Otherwise the plain sum is returned. The corrected pointer appears one clock after the request. Buffers whose length is not a power of two are checked only at the boundary that lies in the step's direction. Power-of-two buffers are checked at both boundaries for either sign of step.

A step is assumed to be no larger than the buffer length, so one fold always suffices. Binding a stack-related register is allowed but is a software choice the block does not police.

Top module: `modwrap_unit`

## Requirements
- R1: After reset every space is disabled, with select, first and last addresses at zero, and `res_vld` is low.
- R2: `res_vld` is high exactly in the cycle after a cycle with `upd_vld` high, and `res_ptr` and `res_wrapped` carry that request's result.
- R3: If the space is disabled or `upd_reg` differs from the space's bound register, `res_ptr` is `(upd_ptr + upd_step) mod 2^16` and `res_wrapped` is 0.
- R4: For a bound update whose sum exceeds the last address, the result is first + (sum − last) − 2.
- R5: For a bound update whose sum is below the first address, the result is last − (first − sum) + 2.
- R6: With a length (last − first + 2) that is not a power of two, a step of zero or more checks only the upper bound, and a sum below the first address passes uncorrected.
- R7: With a non-power-of-two length, a negative step checks only the lower bound, and a sum above the last address passes uncorrected.
- R8: With a power-of-two length, both bounds are checked for any step sign.
- R9: Space 0 (X) and space 1 (Y) hold independent settings, and `upd_space` picks which applies.
- R10: Configuration writes use `cfg_space` and `cfg_field`: code 0 writes the enable from bit 0, code 1 writes the bound register from bits 3:0, code 2 writes the first address, and code 3 writes the last address.
- R11: `res_wrapped` is 1 only when a correction was applied. A bound update whose sum lies inside the buffer returns the sum unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_space | input | 1 | Space written: 0 = X, 1 = Y |
| cfg_field | input | 2 | Field code (see R10) |
| cfg_wdata | input | 16 | Write data |
| upd_vld | input | 1 | Pointer update request |
| upd_space | input | 1 | Space of the update |
| upd_reg | input | 4 | Working-register number being updated |
| upd_ptr | input | 16 | Pointer value before the update |
| upd_step | input | 16 | Signed byte step |
| res_vld | output | 1 | Result valid, one cycle after the request |
| res_ptr | output | 16 | Corrected pointer |
| res_wrapped | output | 1 | A boundary correction was applied |

## Verification
Several properties are checked on every clock. The valid output must lag the request by exactly one cycle. A request for an unbound register must return the plain sum with no wrap flag. A bound request that needs no correction must also return the plain sum. Every fold must land within one word of the buffer whenever the old pointer was inside it and the step was within the length. Only the bench scenarios can show that the corrected value itself is right. They sweep every aligned pointer around both buffers, with steps of both signs, against power-of-two and other lengths, and after reconfiguration. That sweep is what shows the one-sided checking of non-power-of-two buffers, the two-sided checking of power-of-two buffers, and the independence of the two spaces.

// File: rtl/modwrap_pkg.sv
package modwrap_pkg;

  // Configuration field codes on the write port.
  typedef enum logic [1:0] {
    FLD_ENABLE = 2'd0,
    FLD_SELECT = 2'd1,
    FLD_FIRST  = 2'd2,
    FLD_LAST   = 2'd3
  } cfg_field_e;

  localparam int NSPACE = 2;               // X and Y
  localparam int SPW    = $clog2(NSPACE);

endpackage

// File: rtl/modwrap_cfg.sv
module modwrap_cfg
  import modwrap_pkg::*;
#(
  parameter int AW = 16,
  parameter int RW = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [SPW-1:0]             cfg_space,
  input  logic [1:0]                 cfg_field,
  input  logic [AW-1:0]              cfg_wdata,
  output logic [NSPACE-1:0]          sp_en,
  output logic [NSPACE-1:0][RW-1:0]  sp_sel,
  output logic [NSPACE-1:0][AW-1:0]  sp_first,
  output logic [NSPACE-1:0][AW-1:0]  sp_last
);

  for (genvar g = 0; g < NSPACE; g++) begin : g_space
    logic wr_here;
    assign wr_here = cfg_we && (cfg_space == SPW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sp_en[g]    <= 1'b0;
        sp_sel[g]   <= '0;
        sp_first[g] <= '0;
        sp_last[g]  <= '0;
      end else if (wr_here) begin
        case (cfg_field_e'(cfg_field))
          FLD_ENABLE: sp_en[g]    <= cfg_wdata[0];
          FLD_SELECT: sp_sel[g]   <= cfg_wdata[RW-1:0];
          FLD_FIRST:  sp_first[g] <= cfg_wdata;
          FLD_LAST:   sp_last[g]  <= cfg_wdata;
          default:    ;
        endcase
      end
    end
  end

endmodule

// File: rtl/modwrap_calc.sv
module modwrap_calc #(
  parameter int AW   = 16,
  parameter int SW   = 16,
  parameter int WORD = 2
) (
  input  logic [AW-1:0]        old_ptr,
  input  logic signed [SW-1:0] step,
  input  logic [AW-1:0]        buf_first,
  input  logic [AW-1:0]        buf_last,
  output logic [AW-1:0]        new_ptr,
  output logic                 wrapped,
  output logic                 is_pow2
);

  localparam int EW = AW + 2;

  function automatic logic signed [EW-1:0] f_uext(input logic [AW-1:0] a);
    return $signed({2'b00, a});
  endfunction

  function automatic logic signed [EW-1:0] f_sext(input logic signed [SW-1:0] s);
    return EW'(s);
  endfunction

  function automatic logic f_pow2(input logic signed [EW-1:0] l);
    return (l > 0) && ((l & (l - EW'(1))) == '0);
  endfunction

  logic signed [EW-1:0] first_e, last_e, len_e, old_e, step_e, raw_e, new_e, mag_e;
  logic step_neg, past_hi, past_lo, chk_hi, chk_lo, fold_hi, fold_lo, old_inside;

  assign first_e  = f_uext(buf_first);
  assign last_e   = f_uext(buf_last);
  assign old_e    = f_uext(old_ptr);
  assign step_e   = f_sext(step);
  assign len_e    = last_e - first_e + EW'(WORD);
  assign raw_e    = old_e + step_e;
  assign step_neg = step[SW-1];
  assign mag_e    = step_neg ? -step_e : step_e;

  assign is_pow2  = f_pow2(len_e);
  assign past_hi  = raw_e > last_e;
  assign past_lo  = raw_e < first_e;
  assign chk_hi   = is_pow2 || !step_neg;
  assign chk_lo   = is_pow2 || step_neg;
  assign fold_hi  = chk_hi && past_hi;
  assign fold_lo  = chk_lo && past_lo && !fold_hi;
  assign old_inside = (old_e >= first_e) && (old_e <= last_e);

  always_comb begin
    if (fold_hi)      new_e = first_e + (raw_e - last_e) - EW'(WORD);
    else if (fold_lo) new_e = last_e - (first_e - raw_e) + EW'(WORD);
    else              new_e = raw_e;
  end

  assign new_ptr = AW'(new_e);
  assign wrapped = fold_hi || fold_lo;

  // A fold from inside the buffer with a step no longer than the buffer
  // lands within one word of its bounds (R4, R5).
  always_comb begin
    if (wrapped && old_inside && (mag_e <= len_e)) begin
      p_fold_lands_r4: assert ((new_e >= first_e - EW'(WORD - 1)) &&
                               (new_e <= last_e + EW'(WORD - 1)))
        else $error("fold left the buffer");
    end
  end

endmodule

// File: rtl/modwrap_unit.sv
module modwrap_unit
  import modwrap_pkg::*;
#(
  parameter int AW   = 16,
  parameter int SW   = 16,
  parameter int RW   = 4,
  parameter int WORD = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_space,
  input  logic [1:0]           cfg_field,
  input  logic [AW-1:0]        cfg_wdata,
  input  logic                 upd_vld,
  input  logic                 upd_space,
  input  logic [RW-1:0]        upd_reg,
  input  logic [AW-1:0]        upd_ptr,
  input  logic signed [SW-1:0] upd_step,
  output logic                 res_vld,
  output logic [AW-1:0]        res_ptr,
  output logic                 res_wrapped
);

  logic [NSPACE-1:0]          sp_en;
  logic [NSPACE-1:0][RW-1:0]  sp_sel;
  logic [NSPACE-1:0][AW-1:0]  sp_first;
  logic [NSPACE-1:0][AW-1:0]  sp_last;
  logic [NSPACE-1:0][AW-1:0]  c_ptr;
  logic [NSPACE-1:0]          c_wrap;
  logic [NSPACE-1:0]          c_pow2;

  modwrap_cfg #(.AW(AW), .RW(RW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_space (SPW'(cfg_space)),
    .cfg_field (cfg_field),
    .cfg_wdata (cfg_wdata),
    .sp_en     (sp_en),
    .sp_sel    (sp_sel),
    .sp_first  (sp_first),
    .sp_last   (sp_last)
  );

  for (genvar g = 0; g < NSPACE; g++) begin : g_calc
    modwrap_calc #(.AW(AW), .SW(SW), .WORD(WORD)) u_calc (
      .old_ptr   (upd_ptr),
      .step      (upd_step),
      .buf_first (sp_first[g]),
      .buf_last  (sp_last[g]),
      .new_ptr   (c_ptr[g]),
      .wrapped   (c_wrap[g]),
      .is_pow2   (c_pow2[g])
    );
  end

  // Named internal events for the checks below.
  logic          bound_hit;
  logic          hit_fold;
  logic [AW-1:0] plain_sum;
  logic [AW-1:0] sel_ptr;
  logic          sel_pow2;

  assign bound_hit = sp_en[upd_space] && (sp_sel[upd_space] == upd_reg);
  assign hit_fold  = bound_hit && c_wrap[upd_space];
  assign plain_sum = upd_ptr + AW'(upd_step);
  assign sel_ptr   = bound_hit ? c_ptr[upd_space] : plain_sum;
  assign sel_pow2  = c_pow2[upd_space];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld     <= 1'b0;
      res_ptr     <= '0;
      res_wrapped <= 1'b0;
    end else begin
      res_vld <= upd_vld;
      if (upd_vld) begin
        res_ptr     <= sel_ptr;
        res_wrapped <= hit_fold;
      end
    end
  end

  p_vld_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_vld |=> res_vld);

  p_vld_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_vld |=> !res_vld);

  p_miss_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_vld && !bound_hit) |=> (!res_wrapped && res_ptr == $past(plain_sum)));

  p_inside_plain_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_vld && bound_hit && !c_wrap[upd_space]) |=>
      (!res_wrapped && res_ptr == $past(plain_sum)));

  p_pow2_no_escape_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_vld && bound_hit && sel_pow2 &&
     (plain_sum > sp_last[upd_space]) && (upd_ptr <= sp_last[upd_space]) &&
     (upd_ptr >= sp_first[upd_space]) && !upd_step[SW-1]) |=> res_wrapped);

endmodule

// File: tb/sim_modwrap_unit.sv
`timescale 1ns/1ps
module sim_modwrap_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_space = 1'b0;
  logic [1:0]  cfg_field = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic        upd_vld = 1'b0;
  logic        upd_space = 1'b0;
  logic [3:0]  upd_reg = 4'd0;
  logic [15:0] upd_ptr = 16'd0;
  logic signed [15:0] upd_step = 16'sd0;
  logic        res_vld;
  logic [15:0] res_ptr;
  logic        res_wrapped;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Bench-side mirror of the configuration.
  bit en_m [2];
  int sel_m [2];
  int lo_m [2];
  int hi_m [2];

  always #4 clk = ~clk;   // 125 MHz

  modwrap_unit u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_space(cfg_space),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .upd_vld(upd_vld),
    .upd_space(upd_space), .upd_reg(upd_reg), .upd_ptr(upd_ptr),
    .upd_step(upd_step), .res_vld(res_vld), .res_ptr(res_ptr),
    .res_wrapped(res_wrapped)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int sp, input int fld, input int val);
    cfg_we = 1'b1; cfg_space = sp[0]; cfg_field = fld[1:0]; cfg_wdata = val[15:0];
    @(negedge clk);
    cfg_we = 1'b0;
    case (fld)
      0: en_m[sp]  = val[0];
      1: sel_m[sp] = val & 15;
      2: lo_m[sp]  = val & 16'hFFFF;
      default: hi_m[sp] = val & 16'hFFFF;
    endcase
  endtask

  task automatic set_buf(input int sp, input int en, input int sel, input int lo, input int hi);
    cfg_write(sp, 2, lo);
    cfg_write(sp, 3, hi);
    cfg_write(sp, 1, sel);
    cfg_write(sp, 0, en);
  endtask

  // Issue one update and compare the result a cycle later.
  task automatic probe(input int sp, input int rg, input int ptr, input int stp);
    int n, len, exp;
    bit hit, p2, wr;
    string tag;
    upd_vld = 1'b1; upd_space = sp[0]; upd_reg = rg[3:0];
    upd_ptr = ptr[15:0]; upd_step = stp[15:0];
    @(negedge clk);
    upd_vld = 1'b0;
    n   = ptr + stp;
    hit = en_m[sp] && (sel_m[sp] == rg);
    len = hi_m[sp] - lo_m[sp] + 2;
    p2  = (len > 0) && ((len & (len - 1)) == 0);
    wr  = 1'b0;
    tag = "R11";
    if (!hit) tag = "R3";
    else if (n > hi_m[sp]) begin
      if (p2 || stp >= 0) begin n -= len; wr = 1'b1; tag = p2 ? "R8" : "R4"; end
      else tag = "R7";
    end else if (n < lo_m[sp]) begin
      if (p2 || stp < 0) begin n += len; wr = 1'b1; tag = p2 ? "R8" : "R5"; end
      else tag = "R6";
    end
    exp = n & 16'hFFFF;
    check({tag, " res_vld"}, int'(res_vld), 1);
    check({tag, " ptr"}, int'(res_ptr), exp);
    check({tag, " wrapped"}, int'(res_wrapped), int'(wr));
  endtask

  task automatic sweep(input int rg_a, input int rg_b);
    for (int sp = 0; sp < 2; sp++) begin
      for (int k = 0; k < 3; k++) begin
        int rg;
        rg = (k == 0) ? rg_a : (k == 1) ? rg_b : 9;
        for (int p = lo_m[sp] - 8; p <= hi_m[sp] + 8; p += 2) begin
          for (int s = -6; s <= 6; s += 2) probe(sp, rg, p, s);
        end
      end
    end
  endtask

  initial begin
    #(8ns * 190000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 2; i++) begin en_m[i] = 0; sel_m[i] = 0; lo_m[i] = 0; hi_m[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 res_vld in reset", int'(res_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 res_vld after reset", int'(res_vld), 0);
    probe(0, 0, 16'h0004, -6);          // R1: register 0 not bound while disabled
    // R3: plain sum wraps modulo 2^16
    probe(1, 0, 16'hFFFE, 4);
    // R2: no request, no valid
    @(negedge clk);
    check("R2 idle res_vld", int'(res_vld), 0);

    // R10: only bits 3:0 of the select write count
    set_buf(0, 1, 16'hFFF8, 16'h1000, 16'h1008);
    probe(0, 8, 16'h1008, 2);           // expect fold to 0x1000
    check("R10 select low bits", int'(res_ptr), 16'h1000);

    // Phase A: X length 10 (not power of two), Y length 16 (power of two)
    set_buf(0, 1, 8, 16'h1000, 16'h1008);
    set_buf(1, 1, 10, 16'h2000, 16'h200E);
    sweep(8, 10);

    // Phase B: X disabled, Y length 12 bound to register 3 (R9)
    set_buf(0, 0, 8, 16'h1000, 16'h1008);
    set_buf(1, 1, 3, 16'h2000, 16'h200A);
    probe(1, 3, 16'h200A, 2);
    check("R9 Y folds while X off", int'(res_ptr), 16'h2000);
    probe(0, 8, 16'h1008, 2);
    check("R9 X off passes", int'(res_ptr), 16'h100A);
    sweep(8, 3);

    // R2: back-to-back requests keep one-cycle lag
    upd_vld = 1'b1; upd_space = 1'b1; upd_reg = 4'd3; upd_ptr = 16'h2004; upd_step = 16'sd2;
    @(negedge clk);
    check("R2 first of pair", int'(res_ptr), 16'h2006);
    upd_ptr = 16'h2000; upd_step = -16'sd2;
    @(negedge clk);
    upd_vld = 1'b0;
    check("R2 second of pair", int'(res_ptr), 16'h200A);
    @(negedge clk);
    check("R2 valid drops", int'(res_vld), 0);

    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule